// File: doc/BRIEF.md
# Buffer-to-Buffer Credit Transmit Gate

This block controls when the transmit side of a lossless serial link port may begin a frame. At link bring-up it takes the receive buffer count the peer advertised. It holds that count as spendable credit. A queued frame is released only while credit remains. Each released frame spends one credit. Each ready primitive decoded from the peer's incoming stream returns one credit, up to the advertised count.

The block also schedules the ready primitives this port owes its peer. These are single-word primitives that need no credit. They are placed in the word slots that would otherwise carry idle fill between frames, so they cost no extra bandwidth. A framer asks for a frame start, is granted with a one-cycle start pulse and marks the last word of the frame. A separate pulse tells the block that a local receive buffer has been freed and that a ready primitive is owed to the peer.

Top module: `bbc_tx_gate`

## Requirements
- R1: After synchronous reset, `credits` is 0 and `frm_start`, `tx_ready` and `cred_err` are all low.
- R2: While `link_down` is high, `credits` is held at 0, no frame starts, `rrdy_in` has no effect, and a `login_load` stores its count as the new maximum. On the first clock edge where `link_down` is low, `credits` takes the stored maximum.
- R3: A frame is granted in a fill slot (no frame in progress, link up, no load) when `frm_req` is high, `credits` is non-zero and no ready primitive is owed. `frm_start` then pulses for one cycle after that edge and `credits` drops by one at the same edge.
- R4: With `credits` at 0 a pending request waits. A `rrdy_in` pulse raises `credits` by one at the next edge, and the waiting frame is granted one edge later.
- R5: If a frame is granted at the same edge that `rrdy_in` is high, `credits` keeps its value.
- R6: `credits` never exceeds the last loaded count. A `rrdy_in` that arrives with `credits` already at that count leaves `credits` unchanged and sets `cred_err`. `cred_err` stays set until the next `login_load`.
- R7: Each `rdy_owe` pulse produces exactly one `tx_ready` pulse. That pulse occurs only in a fill slot, never while a frame is in progress, at most one per cycle, and it does not change `credits`.
- R8: When a ready primitive is owed and a frame request is pending in the same fill slot, the ready primitive goes first and the frame is granted at the following edge. `frm_start` and `tx_ready` are never high together.
- R9: Between a grant and the `frm_end` pulse that closes the frame, no further frame is granted. The slot reopens at the edge after `frm_end`.
- R10: A `login_load` while the link is up sets both `credits` and the maximum to `login_credits` at the next edge and clears `cred_err`. No grant is made at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_down | input | 1 | Link not operational; holds credit at zero |
| login_load | input | 1 | Strobe: take `login_credits` as the peer's buffer count |
| login_credits | input | CW | Receive buffer count advertised by the peer |
| frm_req | input | 1 | A frame is queued and wants to start |
| frm_end | input | 1 | Pulse on the last word of the frame in progress |
| rrdy_in | input | 1 | Pulse per ready primitive decoded from the peer |
| rdy_owe | input | 1 | Pulse per local buffer freed; one ready primitive owed |
| frm_start | output | 1 | Registered one-cycle grant: frame begins this cycle |
| tx_ready | output | 1 | Registered: send a ready primitive in this fill slot |
| credits | output | CW | Current spendable credit count |
| cred_err | output | 1 | Sticky: ready primitive received with credit already full |

## Verification
The credit path is driven with frames spaced by idle gaps, with back-to-back requests held across a frame in progress, and with requests parked at zero credit. These patterns separate a correct decrement from a missed one, and a grant gated by credit from a grant gated only by the frame in progress. Received ready pulses are placed alone, in the same cycle as a grant, and at the maximum count, which tells increment, the unchanged simultaneous case and the saturation error apart. Owed ready primitives are raised while a frame runs and next to a waiting request, and a burst of them is counted, which shows deferral to fill slots, the priority over frames and the one-for-one count. Link-down entry and release, and a reload while the link is up, check where the count and the maximum come from.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  // What the single transmit word slot carries in a given cycle
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_READY = 2'd1,
    SLOT_FRAME = 2'd2
  } slot_e;
endpackage

// File: rtl/bbc_credit_ctr.sv
module bbc_credit_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_down,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] cnt,
  output logic          has_credit,
  output logic          err
);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] cnt_q, max_q;
  logic          dn_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      max_q <= ZERO;
      dn_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      dn_q <= link_down;
      if (load) begin
        max_q <= load_val;
        err_q <= 1'b0;
      end
      if (link_down) begin
        cnt_q <= ZERO;
      end else if (load) begin
        cnt_q <= load_val;
      end else if (dn_q) begin
        cnt_q <= max_q;
      end else if (take && !give) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (give && !take) begin
        if (cnt_q == max_q) err_q <= 1'b1;
        else                cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt        = cnt_q;
  assign has_credit = (cnt_q != ZERO);
  assign err        = err_q;

  AST_CNT_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= max_q); // R6
  AST_DOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
    link_down |=> (cnt_q == ZERO)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !load) |=> err_q); // R6
endmodule

// File: rtl/bbc_owed_ctr.sv
module bbc_owed_ctr #(
  parameter int OW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic link_down,
  input  logic add,
  input  logic sent,
  output logic pending
);
  localparam logic [OW-1:0] ZERO = '0;
  localparam logic [OW-1:0] FULL = '1;

  logic [OW-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (rst || link_down) begin
      owed_q <= ZERO;
    end else if (add && !sent) begin
      if (owed_q != FULL) owed_q <= owed_q + 1'b1;
    end else if (sent && !add) begin
      owed_q <= owed_q - 1'b1;
    end
  end

  assign pending = (owed_q != ZERO);

  AST_SEND_HAS_OWED: assert property (@(posedge clk) disable iff (rst)
    sent |-> (owed_q != ZERO)); // R7
endmodule

// File: rtl/bbc_slot_sched.sv
module bbc_slot_sched
  import bbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic link_down,
  input  logic load,
  input  logic frm_req,
  input  logic frm_end,
  input  logic has_credit,
  input  logic owed_pend,
  output logic go,
  output logic send,
  output logic start_q,
  output logic ready_q
);
  logic  busy_q;
  logic  open_slot;
  slot_e pick;

  assign open_slot = !busy_q && !link_down && !load;

  always_comb begin
    pick = SLOT_IDLE;
    if (open_slot) begin
      if (owed_pend)                    pick = SLOT_READY;
      else if (frm_req && has_credit)   pick = SLOT_FRAME;
    end
  end

  assign go   = (pick == SLOT_FRAME);
  assign send = (pick == SLOT_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      start_q <= go;
      ready_q <= send;
      if (link_down)             busy_q <= 1'b0;
      else if (busy_q && frm_end) busy_q <= 1'b0;
      else if (go)               busy_q <= 1'b1;
    end
  end

  AST_READY_NOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !frm_end) |=> !ready_q); // R7
endmodule

// File: rtl/bbc_tx_gate.sv
module bbc_tx_gate #(
  parameter int CW = 8,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_down,
  input  logic          login_load,
  input  logic [CW-1:0] login_credits,
  input  logic          frm_req,
  input  logic          frm_end,
  input  logic          rrdy_in,
  input  logic          rdy_owe,
  output logic          frm_start,
  output logic          tx_ready,
  output logic [CW-1:0] credits,
  output logic          cred_err
);
  logic go, send, has_credit, owed_pend;

  bbc_credit_ctr #(.CW(CW)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .link_down  (link_down),
    .load       (login_load),
    .load_val   (login_credits),
    .take       (go),
    .give       (rrdy_in),
    .cnt        (credits),
    .has_credit (has_credit),
    .err        (cred_err)
  );

  bbc_owed_ctr #(.OW(OW)) u_owed (
    .clk       (clk),
    .rst       (rst),
    .link_down (link_down),
    .add       (rdy_owe),
    .sent      (send),
    .pending   (owed_pend)
  );

  bbc_slot_sched u_sched (
    .clk        (clk),
    .rst        (rst),
    .link_down  (link_down),
    .load       (login_load),
    .frm_req    (frm_req),
    .frm_end    (frm_end),
    .has_credit (has_credit),
    .owed_pend  (owed_pend),
    .go         (go),
    .send       (send),
    .start_q    (frm_start),
    .ready_q    (tx_ready)
  );

  AST_START_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> ($past(credits) != '0)); // R3
  AST_START_SPENDS: assert property (@(posedge clk) disable iff (rst)
    (frm_start && !$past(rrdy_in)) |-> (credits == $past(credits) - 1'b1)); // R3
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !$past(rrdy_in)) |-> (credits == $past(credits))); // R7
  AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frm_start, tx_ready})); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> !frm_start); // R9
endmodule

// File: tb/tb_bbc_tx_gate.sv
`timescale 1ns/1ps
module tb_bbc_tx_gate;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst, link_down, login_load, frm_req, frm_end, rrdy_in, rdy_owe;
  logic [CW-1:0] login_credits;
  logic frm_start, tx_ready, cred_err;
  logic [CW-1:0] credits;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bbc_tx_gate #(.CW(CW), .OW(8)) dut (
    .clk(clk), .rst(rst), .link_down(link_down), .login_load(login_load),
    .login_credits(login_credits), .frm_req(frm_req), .frm_end(frm_end),
    .rrdy_in(rrdy_in), .rdy_owe(rdy_owe), .frm_start(frm_start),
    .tx_ready(tx_ready), .credits(credits), .cred_err(cred_err)
  );

  typedef struct packed {
    logic       ld;  logic       lo;  logic [7:0] lv;
    logic       rq;  logic       fe;  logic       rr;  logic ow;
    logic       xs;  logic       xr;  logic [7:0] xc;  logic xe;
    logic [3:0] req;
  } vec_t;

  // fields: ld lo lv | rq fe rr ow | exp start ready credits err | requirement
  localparam vec_t VEC [0:33] = '{
    '{1'b1,1'b1,8'd3, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd2},  // R2 load while down
    '{1'b1,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd2},  // R2 ready ignored
    '{1'b1,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd2},  // R2 no start
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd3,1'b0, 4'd2},  // R2 release
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,8'd2,1'b0, 4'd3},  // R3
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd2,1'b0, 4'd9},  // R9 busy
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd2,1'b0, 4'd9},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,8'd1,1'b0, 4'd3},
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd1,1'b0, 4'd9},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,8'd0,1'b0, 4'd3},
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd9},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd4},  // R4 blocked
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd1,1'b0, 4'd4},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,8'd0,1'b0, 4'd4},
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b0, 4'd9},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd1,1'b0, 4'd4},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,8'd1,1'b0, 4'd5},  // R5
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd1,1'b0, 4'd9},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd2,1'b0, 4'd4},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd3,1'b0, 4'd4},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd3,1'b1, 4'd6},  // R6 saturate
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd3,1'b1, 4'd6},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'd3,1'b1, 4'd7},  // R7
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,8'd3,1'b1, 4'd7},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,8'd2,1'b1, 4'd3},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd2,1'b1, 4'd7},
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd2,1'b1, 4'd7},
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,8'd2,1'b1, 4'd8},  // R8
    '{1'b0,1'b0,8'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,8'd1,1'b1, 4'd8},
    '{1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,8'd1,1'b1, 4'd9},
    '{1'b0,1'b1,8'd5, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd5,1'b0, 4'd10}, // R10
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,8'd5,1'b1, 4'd6},
    '{1'b1,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd0,1'b1, 4'd2},
    '{1'b0,1'b0,8'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'd5,1'b1, 4'd2}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; link_down = 1'b0; login_load = 1'b0; login_credits = '0;
    frm_req = 1'b0; frm_end = 1'b0; rrdy_in = 1'b0; rdy_owe = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    check(1, {20'd0, frm_start, tx_ready, credits, cred_err, 1'b0},
             {20'd0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0});

    for (int i = 0; i < 34; i++) begin
      link_down = VEC[i].ld; login_load = VEC[i].lo; login_credits = VEC[i].lv;
      frm_req = VEC[i].rq; frm_end = VEC[i].fe; rrdy_in = VEC[i].rr; rdy_owe = VEC[i].ow;
      tick();
      check(int'(VEC[i].req),
            {21'd0, frm_start, tx_ready, credits, cred_err},
            {21'd0, VEC[i].xs, VEC[i].xr, VEC[i].xc, VEC[i].xe});
    end
    link_down = 1'b0; login_load = 1'b0; frm_req = 1'b0; frm_end = 1'b0;
    rrdy_in = 1'b0; rdy_owe = 1'b0;

    // R7: burst of three owed primitives, one slot each, no credit change
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        rdy_owe = (k < 3);
        tick();
        if (tx_ready) seen++;
      end
      rdy_owe = 1'b0;
      check(7, seen, 3);
      check(7, credits, 8'd5);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule